// File: doc/BRIEF.md
# Packet Interrupt Coalescing Unit

This unit sits next to a DMA channel and lowers the interrupt rate seen by software by grouping completed-packet events. Each single-cycle packet-completion pulse from the channel adds one to a count of packets that are finished but not yet serviced. Software reads this count, handles packets, and pulses a decrement strobe once for every packet it has finished with.

Two interrupt causes work side by side. The first fires when the pending count climbs to a programmable threshold. The second is a time bound: it fires when packets have been pending for a programmable number of prescaled ticks with no new completion. A third cause simply flags each completed packet. All causes are latched, cleared by writing ones, and gated by an enable register with the same bit layout. A small register port gives access to the causes, enables, threshold, wait bound and count.

Top module: `pkt_coalesce`

## Requirements
- R1: After reset the count, cause register, enable register, threshold and wait bound all read 0, and `irq` is low.
- R2: Each cycle with `pkt_done` high and `pkt_dec` low adds one to the count, which is visible one cycle later. The count stops at 255 and never wraps.
- R3: Each cycle with `pkt_dec` high and `pkt_done` low subtracts one from the count. A decrement when the count is 0 leaves it at 0.
- R4: When `pkt_done` and `pkt_dec` are both high in the same cycle, the count does not change.
- R5: Cause bit 2 (packet completed) is set by every `pkt_done` cycle.
- R6: Cause bit 3 (threshold) is set when an increment makes the count equal to a nonzero threshold. A threshold of 0 never sets it.
- R7: Cause bit 4 (wait bound) is set exactly TICK_DIV × bound cycles after the clock edge that took the last `pkt_done`, provided the count stays nonzero. A new `pkt_done` restarts this interval.
- R8: While the count is 0 the wait timer is held cleared, and a wait bound of 0 disables it. In both cases cause bit 4 is not set.
- R9: Writing the cause register (address 0) clears each cause bit written as 1 and leaves bits written as 0 unchanged.
- R10: The enable register (address 1, same layout as the causes) masks the causes. `irq_cause` equals causes AND enables, and `irq` is the OR of `irq_cause`.
- R11: Register map: 0 cause (bits 2, 3, 4), 1 enable, 2 threshold (low 8 bits, read/write), 3 wait bound (low WB_W bits, read/write), 4 count (read only). `reg_rdata` is a combinational function of `reg_addr`, and unused bits and addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One cycle per completed packet |
| pkt_dec | input | 1 | Software decrement strobe, one per serviced packet |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_cause | output | 8 | Latched causes masked by enables |
| irq | output | 1 | Any enabled cause pending |

## Verification
The assertions assume that `pkt_done` and `pkt_dec` are ordinary synchronous levels sampled once per edge. They also assume that reset is asserted before the first checked edge, so the count and cause registers start from known zeros. The bench drives every input on the falling clock edge and releases reset in the same way. It reprograms the threshold and wait bound only while the unit is idle, so the wait counter never starts above a newly written, smaller bound.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
   localparam int PCU_ADDR_W = 3;
   localparam int CAUSE_W    = 8;

   localparam int BIT_PKT  = 2;
   localparam int BIT_THR  = 3;
   localparam int BIT_WAIT = 4;

   localparam logic [CAUSE_W-1:0] CAUSE_IMPL =
      CAUSE_W'((1 << BIT_PKT) | (1 << BIT_THR) | (1 << BIT_WAIT));

   typedef enum logic [PCU_ADDR_W-1:0] {
      REG_CAUSE  = 3'd0,
      REG_ENABLE = 3'd1,
      REG_THRESH = 3'd2,
      REG_WAITB  = 3'd3,
      REG_COUNT  = 3'd4
   } pcu_reg_e;
endpackage

// File: rtl/pcu_pkt_counter.sv
`timescale 1ns/1ps
module pcu_pkt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   input  logic [CNT_W-1:0] thresh,
   output logic [CNT_W-1:0] cnt_q,
   output logic             thr_hit
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_d;
   logic             up, down;

   always_comb begin
      up    = inc && !dec && (cnt_q != CNT_MAX);
      down  = dec && !inc && (cnt_q != '0);
      cnt_d = cnt_q;
      if (up)
         cnt_d = cnt_q + 1'b1;
      else if (down)
         cnt_d = cnt_q - 1'b1;
   end

   assign thr_hit = up && (thresh != '0) && (cnt_d == thresh);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end
endmodule

// File: rtl/pcu_wait_timer.sv
`timescale 1ns/1ps
module pcu_wait_timer #(
   parameter int WB_W     = 16,
   parameter int TICK_DIV = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            pending,
   input  logic [WB_W-1:0] bound,
   output logic            expire
);
   logic            armed;
   logic            tick;
   logic [WB_W-1:0] wcnt_q;
   logic            last_tick;

   assign armed = pending && (bound != '0) && !restart;

   generate
      if (TICK_DIV > 1) begin : g_prescale
         localparam int PW = $clog2(TICK_DIV);
         localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n || !armed)
               pre_q <= '0;
            else if (pre_q == PRE_LAST)
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end
         assign tick = armed && (pre_q == PRE_LAST);
      end else begin : g_direct
         assign tick = armed;
      end
   endgenerate

   assign last_tick = (wcnt_q + WB_W'(1)) == bound;
   assign expire    = tick && last_tick;

   always_ff @(posedge clk) begin
      if (!rst_n || !armed)
         wcnt_q <= '0;
      else if (tick) begin
         if (last_tick)
            wcnt_q <= '0;
         else
            wcnt_q <= wcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pcu_cause_regs.sv
`timescale 1ns/1ps
module pcu_cause_regs
   import pcu_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_W-1:0] set_vec,
   input  logic               clr_we,
   input  logic [CAUSE_W-1:0] clr_vec,
   input  logic               en_we,
   input  logic [CAUSE_W-1:0] en_wdata,
   output logic [CAUSE_W-1:0] cause_q,
   output logic [CAUSE_W-1:0] en_q,
   output logic [CAUSE_W-1:0] masked
);
   generate
      for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
         if (CAUSE_IMPL[i]) begin : g_impl
            always_ff @(posedge clk) begin
               if (!rst_n)
                  cause_q[i] <= 1'b0;
               else if (set_vec[i])
                  cause_q[i] <= 1'b1;
               else if (clr_we && clr_vec[i])
                  cause_q[i] <= 1'b0;
            end
            always_ff @(posedge clk) begin
               if (!rst_n)
                  en_q[i] <= 1'b0;
               else if (en_we)
                  en_q[i] <= en_wdata[i];
            end
         end else begin : g_none
            assign cause_q[i] = 1'b0;
            assign en_q[i]    = 1'b0;
         end
      end
   endgenerate

   assign masked = cause_q & en_q;

   logic unused_bits;
   assign unused_bits = ^{set_vec & ~CAUSE_IMPL, clr_vec & ~CAUSE_IMPL,
                          en_wdata & ~CAUSE_IMPL};
endmodule

// File: rtl/pkt_coalesce.sv
`timescale 1ns/1ps
module pkt_coalesce
   import pcu_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int WB_W     = 16,
   parameter int TICK_DIV = 64,
   parameter int DATA_W   = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pkt_done,
   input  logic                  pkt_dec,
   input  logic                  reg_we,
   input  logic [PCU_ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic [CAUSE_W-1:0]    irq_cause,
   output logic                  irq
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("pkt_coalesce: CNT_W must lie in 1..DATA_W");
      end
      if (WB_W < 1 || WB_W > DATA_W) begin : g_bad_wb
         $error("pkt_coalesce: WB_W must lie in 1..DATA_W");
      end
      if (TICK_DIV < 1) begin : g_bad_tick
         $error("pkt_coalesce: TICK_DIV must be at least 1");
      end
      if (DATA_W < CAUSE_W) begin : g_bad_data
         $error("pkt_coalesce: DATA_W narrower than cause register");
      end
   endgenerate

   pcu_reg_e         addr_e;
   logic [CNT_W-1:0] thr_q;
   logic [WB_W-1:0]  wb_q;
   logic [CNT_W-1:0] cnt_q;
   logic             thr_hit;
   logic             wait_exp;
   logic [CAUSE_W-1:0] set_vec, cause_q, en_q;

   assign addr_e = pcu_reg_e'(reg_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q <= '0;
         wb_q  <= '0;
      end else if (reg_we) begin
         if (addr_e == REG_THRESH) thr_q <= reg_wdata[CNT_W-1:0];
         if (addr_e == REG_WAITB)  wb_q  <= reg_wdata[WB_W-1:0];
      end
   end

   pcu_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (pkt_done),
      .dec     (pkt_dec),
      .thresh  (thr_q),
      .cnt_q   (cnt_q),
      .thr_hit (thr_hit)
   );

   pcu_wait_timer #(.WB_W(WB_W), .TICK_DIV(TICK_DIV)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (pkt_done),
      .pending (cnt_q != '0),
      .bound   (wb_q),
      .expire  (wait_exp)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[BIT_PKT]  = pkt_done;
      set_vec[BIT_THR]  = thr_hit;
      set_vec[BIT_WAIT] = wait_exp;
   end

   pcu_cause_regs u_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_we   (reg_we && addr_e == REG_CAUSE),
      .clr_vec  (reg_wdata[CAUSE_W-1:0]),
      .en_we    (reg_we && addr_e == REG_ENABLE),
      .en_wdata (reg_wdata[CAUSE_W-1:0]),
      .cause_q  (cause_q),
      .en_q     (en_q),
      .masked   (irq_cause)
   );

   assign irq = |irq_cause;

   always_comb begin
      reg_rdata = '0;
      case (addr_e)
         REG_CAUSE:  reg_rdata[CAUSE_W-1:0] = cause_q;
         REG_ENABLE: reg_rdata[CAUSE_W-1:0] = en_q;
         REG_THRESH: reg_rdata[CNT_W-1:0]   = thr_q;
         REG_WAITB:  reg_rdata[WB_W-1:0]    = wb_q;
         REG_COUNT:  reg_rdata[CNT_W-1:0]   = cnt_q;
         default:    reg_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/pcu_checker.sv
`timescale 1ns/1ps
module pcu_checker
   import pcu_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pkt_done,
   input logic               pkt_dec,
   input logic [CNT_W-1:0]   cnt_q,
   input logic [CAUSE_W-1:0] cause_q,
   input logic [CAUSE_W-1:0] en_q,
   input logic [CAUSE_W-1:0] irq_cause
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && pkt_done && !pkt_dec) |=> (cnt_q == CNT_MAX));

   assert_dec_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && pkt_dec && !pkt_done) |=> (cnt_q == '0));

   assert_tie_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && pkt_dec) |=> $stable(cnt_q));

   assert_pkt_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |=> cause_q[BIT_PKT]);

   assert_thr_from_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause_q[BIT_THR]) |-> $past(pkt_done));

   assert_wait_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause_q[BIT_WAIT]) |-> ($past(cnt_q) != '0));

   assert_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_cause & ~en_q) == '0);
endmodule

bind pkt_coalesce pcu_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pkt_done  (pkt_done),
   .pkt_dec   (pkt_dec),
   .cnt_q     (cnt_q),
   .cause_q   (cause_q),
   .en_q      (en_q),
   .irq_cause (irq_cause)
);

// File: tb/tb_pkt_coalesce.sv
`timescale 1ns/1ps
module tb_pkt_coalesce;
   localparam int TDIV = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pkt_done, pkt_dec, reg_we;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [7:0]  irq_cause;
   logic        irq;

   int total = 0;
   int bad   = 0;
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   pkt_coalesce #(.CNT_W(8), .WB_W(16), .TICK_DIV(TDIV), .DATA_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_dec(pkt_dec),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_cause(irq_cause), .irq(irq));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pkt_done = 1'b0; pkt_dec = 1'b0;
      reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic pulses(int n);
      @(negedge clk);
      pkt_done = 1'b1;
      repeat (n) @(negedge clk);
      pkt_done = 1'b0;
   endtask

   task automatic decs(int n);
      @(negedge clk);
      pkt_dec = 1'b1;
      repeat (n) @(negedge clk);
      pkt_dec = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), rv);
         chk("R1 reset register", rv, 32'h0);
      end
      chk("R1 reset irq", {31'd0, irq}, 32'h0);
   endtask

   task automatic t_count();
      do_reset();
      pulses(5);
      rd(3'd4, rv); chk("R2 count after 5", rv, 32'd5);
      decs(2);
      rd(3'd4, rv); chk("R3 count after 2 dec", rv, 32'd3);
      rd(3'd0, rv); chk("R5 packet cause bit 2", rv & 32'h4, 32'h4);
   endtask

   task automatic t_saturate();
      do_reset();
      pulses(260);
      rd(3'd4, rv); chk("R2 saturate at 255", rv, 32'd255);
      decs(1);
      rd(3'd4, rv); chk("R2 dec from 255", rv, 32'd254);
   endtask

   task automatic t_floor();
      do_reset();
      decs(3);
      rd(3'd4, rv); chk("R3 dec at zero", rv, 32'd0);
      pulses(1);
      decs(4);
      rd(3'd4, rv); chk("R3 floor after drain", rv, 32'd0);
   endtask

   task automatic t_tie();
      do_reset();
      pulses(2);
      @(negedge clk);
      pkt_done = 1'b1; pkt_dec = 1'b1;
      repeat (3) @(negedge clk);
      pkt_done = 1'b0; pkt_dec = 1'b0;
      rd(3'd4, rv); chk("R4 simultaneous hold", rv, 32'd2);
   endtask

   task automatic t_thresh();
      do_reset();
      wr(3'd2, 32'd3);
      rd(3'd2, rv); chk("R11 threshold readback", rv, 32'd3);
      pulses(2);
      rd(3'd0, rv); chk("R6 below threshold", rv & 32'h8, 32'h0);
      pulses(1);
      rd(3'd0, rv); chk("R6 at threshold", rv & 32'h8, 32'h8);
      wr(3'd0, 32'h8);
      rd(3'd0, rv); chk("R9 clear bit 3 only", rv & 32'h1C, 32'h4);
      wr(3'd0, 32'h4);
      rd(3'd0, rv); chk("R9 clear bit 2", rv & 32'h1C, 32'h0);
   endtask

   task automatic t_thresh_zero();
      do_reset();
      pulses(20);
      rd(3'd0, rv); chk("R6 threshold 0 disabled", rv & 32'h8, 32'h0);
   endtask

   task automatic t_wait();
      do_reset();
      wr(3'd3, 32'd3);
      rd(3'd3, rv); chk("R11 wait bound readback", rv, 32'd3);
      pulses(1);
      repeat (8) @(posedge clk);
      pulses(1);
      repeat (11) @(posedge clk);
      @(negedge clk);
      rd(3'd0, rv); chk("R7 wait not yet expired after restart", rv & 32'h10, 32'h0);
      @(posedge clk);
      @(negedge clk);
      rd(3'd0, rv); chk("R7 wait expired on time", rv & 32'h10, 32'h10);
   endtask

   task automatic t_wait_hold();
      do_reset();
      wr(3'd3, 32'd1);
      repeat (20) @(negedge clk);
      rd(3'd0, rv); chk("R8 timer held at count 0", rv & 32'h10, 32'h0);
      wr(3'd3, 32'd0);
      pulses(1);
      repeat (40) @(negedge clk);
      rd(3'd0, rv); chk("R8 wait bound 0 disabled", rv & 32'h10, 32'h0);
   endtask

   task automatic t_mask();
      do_reset();
      wr(3'd2, 32'd1);
      pulses(1);
      @(negedge clk);
      chk("R10 masked irq", {31'd0, irq}, 32'h0);
      wr(3'd1, 32'h4);
      rd(3'd1, rv); chk("R11 enable readback", rv, 32'h4);
      chk("R10 irq_cause masked", {24'd0, irq_cause}, 32'h4);
      chk("R10 irq asserted", {31'd0, irq}, 32'h1);
      wr(3'd0, 32'h4);
      chk("R9 R10 irq after clear", {31'd0, irq}, 32'h0);
   endtask

   initial begin
      t_reset();
      t_count();
      t_saturate();
      t_floor();
      t_tie();
      t_thresh();
      t_thresh_zero();
      t_wait();
      t_wait_hold();
      t_mask();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #500000;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule